// File: doc/BRIEF.md
# Wait-for-interrupt/event sleep controller

This per-core controller parks a processor core in a clock-gated low-power state when the pipeline issues one of two wait operations. It then decides when to restart the core. The interrupt-style wait sleeps until an interrupt, a debug request or a warm-reset request arrives. The event-style wait also wakes on events. There are four event sources: a global send-event broadcast, a local send-event pulse, a periodic timer event and a monitor-cleared pulse from the exclusive monitor.

Every event sets a sticky one-bit pending flag. An event-style wait issued while the flag is set clears it and completes at once, without sleeping. Because of this flag, an event that arrives just before the core goes to sleep is never lost.

The block has three outputs. The core clock enable is low for as long as the core sleeps. A sleeping flag reports the low-power state. A completion strobe tells the pipeline that the wait operation has retired.

Top module: `wait_sleep_ctrl`

## Requirements
- R1: After reset the core is awake (clock enable 1, sleeping 0, completion 0) and the event flag is clear, so the first event-style wait sleeps. Reset also wakes a sleeping core at once.
- R2: An interrupt-style wait request seen at a clock edge drives clock enable to 0 and sleeping to 1 from that edge on.
- R3: An interrupt-style sleep ends at the edge that sees an interrupt, debug or warm-reset request. From that edge, clock enable is 1 and the completion strobe is 1 for that one cycle.
- R4: Events on any of the four sources (broadcast, local, timer, monitor-cleared) do not wake an interrupt-style sleep.
- R5: Every event source sets the sticky flag, whatever the core state is. The flag stays set until an event-style wait consumes it, and it is still set after an interrupt-style sleep.
- R6: An event-style wait issued with the flag set completes at that edge. The clock enable stays 1, the completion strobe is 1 for one cycle, and the flag is cleared, so the next event-style wait sleeps.
- R7: An event-style wait issued with the flag clear sleeps. An event during that sleep sets the flag at the edge that sees it. The next edge wakes the core (clock enable 1, completion 1) and clears the flag.
- R8: An event-style sleep also ends at the edge that sees an interrupt, debug or warm-reset request, and the flag is clear afterwards.
- R9: An event that arrives in the same cycle as a consuming event-style wait is kept in the flag, so the next event-style wait completes at once.
- R10: If both wait requests are raised in the same cycle, the core takes the interrupt-style wait. Wait requests seen while the core sleeps are ignored.
- R11: Sleeping is always the inverse of clock enable. The completion strobe is 1 only in the single cycle after a wait completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Ungated clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wfi_req_i | input | 1 | Interrupt-style wait request from the pipeline |
| wfe_req_i | input | 1 | Event-style wait request from the pipeline |
| irq_i | input | 1 | Interrupt pending |
| dbg_req_i | input | 1 | Debug halt request |
| wake_rst_i | input | 1 | Warm-reset request (wake source) |
| sev_local_i | input | 1 | Local send-event pulse |
| sev_bcast_i | input | 1 | Global send-event broadcast |
| timer_evt_i | input | 1 | Periodic timer event |
| mon_clr_i | input | 1 | Exclusive monitor went to open |
| clk_en_o | output | 1 | Core clock enable |
| sleep_o | output | 1 | Core is in low-power wait |
| done_o | output | 1 | Wait operation completed (one cycle) |

## Verification
The assertions treat every input as a synchronous level that is sampled only at the rising edge. They assume no input carries any meaning between edges. The assertions place no rule on how requests and wake sources overlap, because the block itself defines what overlap does.

The stimulus changes inputs only on the falling edge and holds each pulse for exactly one cycle. The random phase raises wait requests only while the core is awake, with a small share of cycles carrying both requests at once. Directed steps cover requests made during sleep and events that coincide with a consuming wait.

// File: rtl/wait_sleep_pkg.sv
`timescale 1ns/1ps
package wait_sleep_pkg;
  localparam int NUM_EVT_SRC  = 4;
  localparam int NUM_WAKE_SRC = 3;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_WFI = 2'd1,
    ST_WFE = 2'd2
  } slp_state_e;
endpackage

// File: rtl/wake_evt_reg.sv
`timescale 1ns/1ps
module wake_evt_reg #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               consume_i,
  output logic               pending_o
);
  logic ev_q;

  // new events win over a consume in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= 1'b0;
    else         ev_q <= (ev_q & ~consume_i) | (|evt_i);
  end

  assign pending_o = ev_q;
endmodule

// File: rtl/wake_decode.sv
`timescale 1ns/1ps
module wake_decode
  import wait_sleep_pkg::*;
#(
  parameter int NUM_WAKE = 3
) (
  input  slp_state_e          st_i,
  input  logic [NUM_WAKE-1:0] wake_src_i,
  input  logic                ev_pend_i,
  output logic                wake_o
);
  always_comb begin
    unique case (st_i)
      ST_WFI:  wake_o = |wake_src_i;
      ST_WFE:  wake_o = (|wake_src_i) | ev_pend_i;
      default: wake_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wait_sleep_ctrl.sv
`timescale 1ns/1ps
module wait_sleep_ctrl
  import wait_sleep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wfi_req_i,
  input  logic wfe_req_i,
  input  logic irq_i,
  input  logic dbg_req_i,
  input  logic wake_rst_i,
  input  logic sev_local_i,
  input  logic sev_bcast_i,
  input  logic timer_evt_i,
  input  logic mon_clr_i,
  output logic clk_en_o,
  output logic sleep_o,
  output logic done_o
);
  slp_state_e               st_q, st_d;
  logic                     done_q, done_d;
  logic                     clk_en_q;
  logic                     consume;
  logic                     ev_pend;
  logic                     wake;
  logic [NUM_EVT_SRC-1:0]   evt_vec;
  logic [NUM_WAKE_SRC-1:0]  wake_vec;

  assign evt_vec  = {sev_bcast_i, sev_local_i, timer_evt_i, mon_clr_i};
  assign wake_vec = {irq_i, dbg_req_i, wake_rst_i};

  wake_evt_reg #(.NUM_SRC(NUM_EVT_SRC)) i_evt_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_vec),
    .consume_i (consume),
    .pending_o (ev_pend)
  );

  wake_decode #(.NUM_WAKE(NUM_WAKE_SRC)) i_wake_dec (
    .st_i       (st_q),
    .wake_src_i (wake_vec),
    .ev_pend_i  (ev_pend),
    .wake_o     (wake)
  );

  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    consume = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (wfi_req_i) begin
          st_d = ST_WFI;
        end else if (wfe_req_i) begin
          if (ev_pend) begin
            done_d  = 1'b1;
            consume = 1'b1;
          end else begin
            st_d = ST_WFE;
          end
        end
      end
      ST_WFI: begin
        if (wake) begin
          st_d   = ST_RUN;
          done_d = 1'b1;
        end
      end
      ST_WFE: begin
        if (wake) begin
          st_d    = ST_RUN;
          done_d  = 1'b1;
          consume = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_RUN;
      done_q   <= 1'b0;
      clk_en_q <= 1'b1;
    end else begin
      st_q     <= st_d;
      done_q   <= done_d;
      clk_en_q <= (st_d == ST_RUN);
    end
  end

  assign clk_en_o = clk_en_q;
  assign sleep_o  = (st_q != ST_RUN);
  assign done_o   = done_q;
endmodule

// File: rtl/wait_sleep_ctrl_chk.sv
`timescale 1ns/1ps
module wait_sleep_ctrl_chk
  import wait_sleep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wfi_req_i,
  input logic       wfe_req_i,
  input logic       irq_i,
  input logic       dbg_req_i,
  input logic       wake_rst_i,
  input logic       sev_local_i,
  input logic       sev_bcast_i,
  input logic       timer_evt_i,
  input logic       mon_clr_i,
  input logic       clk_en_o,
  input logic       sleep_o,
  input logic       done_o,
  input slp_state_e st_q,
  input logic       ev_pend
);
  logic any_wake, any_evt;
  assign any_wake = irq_i | dbg_req_i | wake_rst_i;
  assign any_evt  = sev_local_i | sev_bcast_i | timer_evt_i | mon_clr_i;

  a_r2_wfi_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) && wfi_req_i |=> !clk_en_o && sleep_o);

  a_r3_wfi_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WFI) && any_wake |=> clk_en_o && done_o);

  a_r4_wfi_deaf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WFI) && !any_wake |=> sleep_o && !done_o);

  a_r5_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_evt |=> ev_pend);

  a_r6_fast_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) && !wfi_req_i && wfe_req_i && ev_pend && !any_evt
    |=> clk_en_o && done_o && !ev_pend);

  a_r7_evt_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WFE) && ev_pend && !any_evt |=> clk_en_o && done_o && !ev_pend);

  a_r8_wfe_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WFE) && any_wake |=> clk_en_o && done_o);

  a_r11_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !clk_en_o && !done_o);

  a_r11_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> clk_en_o);
endmodule

bind wait_sleep_ctrl wait_sleep_ctrl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wfi_req_i   (wfi_req_i),
  .wfe_req_i   (wfe_req_i),
  .irq_i       (irq_i),
  .dbg_req_i   (dbg_req_i),
  .wake_rst_i  (wake_rst_i),
  .sev_local_i (sev_local_i),
  .sev_bcast_i (sev_bcast_i),
  .timer_evt_i (timer_evt_i),
  .mon_clr_i   (mon_clr_i),
  .clk_en_o    (clk_en_o),
  .sleep_o     (sleep_o),
  .done_o      (done_o),
  .st_q        (st_q),
  .ev_pend     (ev_pend)
);

// File: tb/test_wait_sleep_ctrl.sv
`timescale 1ns/1ps
module test_wait_sleep_ctrl;
  localparam logic [8:0] B_WFI  = 9'h100;
  localparam logic [8:0] B_WFE  = 9'h080;
  localparam logic [8:0] B_IRQ  = 9'h040;
  localparam logic [8:0] B_DBG  = 9'h020;
  localparam logic [8:0] B_WRST = 9'h010;
  localparam logic [8:0] B_SEVL = 9'h008;
  localparam logic [8:0] B_SEV  = 9'h004;
  localparam logic [8:0] B_TMR  = 9'h002;
  localparam logic [8:0] B_MON  = 9'h001;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [8:0] stim = '0;
  logic clk_en, slp, done;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // model state: 0 run, 1 wfi sleep, 2 wfe sleep
  int m_st = 0;
  bit m_ev = 0, m_done = 0;

  always #5 clk = ~clk;

  wait_sleep_ctrl i_wait_sleep_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .wfi_req_i(stim[8]), .wfe_req_i(stim[7]),
    .irq_i(stim[6]), .dbg_req_i(stim[5]), .wake_rst_i(stim[4]),
    .sev_local_i(stim[3]), .sev_bcast_i(stim[2]),
    .timer_evt_i(stim[1]), .mon_clr_i(stim[0]),
    .clk_en_o(clk_en), .sleep_o(slp), .done_o(done)
  );

  function automatic logic [2:0] expect_out();
    return {m_st == 0, m_st != 0, m_done};
  endfunction

  task automatic check(input string tag);
    logic [2:0] act, exp;
    act = {clk_en, slp, done};
    exp = expect_out();
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {clk_en,sleep,done} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic [8:0] s);
    bit ev_in, wk;
    ev_in  = |s[3:0];
    wk     = |s[6:4];
    m_done = 0;
    case (m_st)
      0: begin
        if (s[8]) m_st = 1;
        else if (s[7]) begin
          if (m_ev) begin m_done = 1; m_ev = 0; end
          else m_st = 2;
        end
      end
      1: if (wk) begin m_st = 0; m_done = 1; end
      default: if (wk || m_ev) begin m_st = 0; m_done = 1; m_ev = 0; end
    endcase
    m_ev = m_ev | ev_in;
  endtask

  task automatic cyc(input logic [8:0] s, input string tag);
    @(negedge clk);
    stim = s;
    @(posedge clk);
    model_step(s);
    #2;
    check(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    stim = '0;
    rst_ni = 1'b0;
    m_st = 0; m_ev = 0; m_done = 0;
    #2;
    check(tag);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    check("R1 reset state");
    @(negedge clk);
    rst_ni = 1'b1;

    cyc(B_WFE, "R1 flag clear after reset, wfe sleeps");
    cyc(B_IRQ, "R8 irq wakes wfe");
    cyc(B_WFI, "R2 wfi enters sleep");
    cyc(B_SEV, "R4 broadcast ignored");
    cyc(B_TMR | B_MON | B_SEVL, "R4 other events ignored");
    cyc(B_WFE, "R10 request during sleep ignored");
    cyc(B_DBG, "R3 debug wakes wfi");
    cyc('0, "R11 done single cycle");
    cyc(B_WFE, "R5 flag kept through wfi sleep, fast return");
    cyc(B_WFE, "R6 flag consumed, wfe sleeps");
    cyc(B_MON, "R7 monitor event sets flag");
    cyc('0, "R7 wake next edge");
    cyc('0, "R11 done low");
    cyc(B_WFE, "R7 flag cleared by wake");
    cyc(B_WRST, "R8 warm reset wakes wfe");
    cyc(B_WFI, "R3 wfi again");
    cyc(B_IRQ, "R3 irq wakes wfi");
    cyc(B_SEVL, "R5 local event while awake");
    cyc(B_WFE | B_TMR, "R9 consume with coincident event");
    cyc(B_WFE, "R9 coincident event kept");
    cyc(B_SEV, "R5 set flag");
    cyc(B_WFI | B_WFE, "R10 both requests take wfi");
    cyc('0, "R10 wfi ignores pending flag");
    cyc(B_IRQ, "R10 irq wakes");
    cyc(B_WFI, "R2 sleep before reset");
    do_reset("R1 reset wakes core");
    cyc(B_WFE, "R1 reset cleared flag");
    cyc(B_DBG, "R8 debug wakes wfe");

    for (int i = 0; i < 3000; i++) begin
      logic [8:0] s;
      int r;
      s = '0;
      if (m_st == 0) begin
        r = $urandom_range(0, 99);
        if (r < 10) s |= B_WFI;
        else if (r < 22) s |= B_WFE;
        else if (r < 24) s |= B_WFI | B_WFE;
      end
      for (int b = 0; b < 4; b++) if ($urandom_range(0, 99) < 4) s[b] = 1'b1;
      for (int b = 4; b < 7; b++) if ($urandom_range(0, 99) < 3) s[b] = 1'b1;
      cyc(s, "R11 random vs model");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule